// File: doc/BRIEF.md
# Triggered Frame Capture and Sample Unpacker

This block sits behind an ADC word interface that delivers two 16-bit samples packed into each 32-bit word. It waits for a rising edge on an external trigger that follows the laser pulse timing. On that edge it takes in one fixed-length frame of words and then replays the frame as a stream of single 16-bit samples, one sample per cycle, with a valid flag. The first and last samples of each frame are marked.

The output can carry only one sample per cycle, while the input can deliver two. An internal word buffer absorbs this mismatch. Because the capture window is bounded, the buffer has a bounded worst-case fill. A second trigger edge that arrives while a frame is still being taken in or replayed is not acted on. It is tallied in a saturating counter instead. A sticky flag records that the buffer was ever full. The trigger input is asynchronous, so it passes through a synchroniser before edge detection.

Top module: `trig_frame_unpacker`

## Requirements
- R1: After reset, smp_valid, frame_start and frame_end are 0, missed_trig is 0 and buf_overflow is 0.
- R2: Capture begins only on a rising edge of trig_in, seen through a two-flop synchroniser. The first word taken is one presented at least four clock edges after trig_in rises. Words presented while no frame is open produce no output.
- R3: A frame takes exactly FRAME_SAMPLES/2 valid words (8192 samples by default). Valid words that arrive after the frame's last word, while it is still being replayed, are discarded.
- R4: Each word is emitted as two consecutive samples: bits [15:0] first, then bits [31:16]. smp_valid is high in every cycle that smp_out carries a sample.
- R5: frame_start is high with the first sample of a frame and frame_end with its last sample. Each is high for exactly one sample per frame, and never without smp_valid.
- R6: A rising trigger edge that arrives while a frame is open (capturing or replaying) starts no frame. It increments missed_trig, which saturates at its maximum.
- R7: A trigger held high after a frame has finished does not start another frame.
- R8: When words arrive no faster than one every two cycles, every captured sample is emitted exactly once and in arrival order.
- R9: buf_overflow goes high once the word buffer becomes full and stays high until reset. A word that arrives when the buffer is full, and no read frees a slot, is dropped.
- R10: After frame_end, the next rising trigger edge starts a new frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 32 | Packed pair of samples, lower sample in bits [15:0] |
| word_valid | input | 1 | word_in carries a word this cycle |
| trig_in | input | 1 | Asynchronous frame trigger, active on its rising edge |
| smp_out | output | 16 | Unpacked sample |
| smp_valid | output | 1 | smp_out holds a sample |
| frame_start | output | 1 | First sample of a frame |
| frame_end | output | 1 | Last sample of a frame |
| missed_trig | output | MISS_W | Saturating count of trigger edges ignored while busy |
| buf_overflow | output | 1 | Sticky: the word buffer has been full |

## Verification
The assertions assume two things about the inputs. First, trig_in stays at a level for at least three cycles, so every edge survives the synchroniser. Second, reset is held for several cycles, so the synchroniser flops have settled before capture can begin. The stimulus moves the trigger only in steps of several cycles and holds reset for five cycles. It feeds words at one every two cycles wherever the order and completeness of samples are scored. A single full-rate frame, run against a deliberately small buffer, is used only to reach the overflow flag. For that frame sample scoring is switched off and only framing and the sticky flag are checked.

// File: rtl/tfu_pkg.sv
package tfu_pkg;

    localparam int SMP_W  = 16;
    localparam int LANES  = 2;
    localparam int WORD_W = SMP_W * LANES;

    typedef logic [SMP_W-1:0]  sample_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DRAIN   = 2'd2
    } cap_state_e;

    typedef struct packed {
        sample_t data;
        logic    sof;
        logic    eof;
    } smp_beat_t;

    // Select one sample lane of a packed word; lane 0 is the low half.
    function automatic sample_t lane_of(word_t w, logic sel);
        return sel ? w[WORD_W-1:SMP_W] : w[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/tfu_trig_sync.sv
module tfu_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    output logic trig_rise
);
    // chain[SYNC_STAGES-1] is the synchronised level, the last flop its delay
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], trig_async};
    end

    assign trig_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // R2: a detected edge lasts exactly one cycle
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        trig_rise |=> !trig_rise);

endmodule

// File: rtl/tfu_word_fifo.sv
module tfu_word_fifo
    import tfu_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  word_t                      wr_data,
    input  logic                       rd_en,
    output word_t                      rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_ok, rd_ok;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rd_ok = rd_en && !empty;
    assign wr_ok = wr_en && (!full || rd_ok);

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];

    // R8: the reader never pulls from an empty buffer
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

    // R9: a write against a full buffer without a read leaves the fill unchanged
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

endmodule

// File: rtl/tfu_frame_ctrl.sv
module tfu_frame_ctrl
    import tfu_pkg::*;
#(
    parameter int FRAME_WORDS = 4096,
    parameter int MISS_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_rise,
    input  logic              word_valid,
    input  logic              last_pop,
    output cap_state_e        state,
    output logic              wr_en,
    output logic              frame_arm,
    output logic [MISS_W-1:0] missed
);
    localparam int FW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

    logic [FW-1:0] word_cnt;
    logic          last_word;

    assign wr_en     = (state == ST_CAPTURE) && word_valid;
    assign frame_arm = (state == ST_IDLE) && trig_rise;
    assign last_word = (word_cnt == FW'(FRAME_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            word_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    word_cnt <= '0;
                    if (trig_rise) state <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    if (word_valid) begin
                        if (last_word) state <= ST_DRAIN;
                        else           word_cnt <= word_cnt + FW'(1);
                    end
                end
                ST_DRAIN: begin
                    if (last_pop) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) missed <= '0;
        else if (trig_rise && (state != ST_IDLE) && (missed != '1))
            missed <= missed + MISS_W'(1);
    end

    // R2: without a trigger edge an idle controller stays idle
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !trig_rise) |=> state == ST_IDLE);

    // R6: the missed count moves only after an edge seen while busy
    miss_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(missed) |-> ($past(trig_rise) && $past(state) != ST_IDLE));

    // R3: the replay phase never accepts words
    drain_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> !wr_en);

endmodule

// File: rtl/tfu_unpacker.sv
module tfu_unpacker
    import tfu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_t     head,
    input  logic      have_word,
    input  logic      one_left,
    input  logic      drain_mode,
    input  logic      frame_arm,
    output logic      pop,
    output logic      last_pop,
    output smp_beat_t beat,
    output logic      beat_valid
);
    logic phase;       // 0: low lane next, 1: high lane next
    logic first_pend;  // next emitted sample opens a frame

    assign pop      = have_word && phase;
    assign last_pop = pop && drain_mode && one_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= 1'b0;
            first_pend <= 1'b0;
            beat_valid <= 1'b0;
            beat       <= '0;
        end else begin
            beat_valid <= have_word;
            if (have_word) begin
                beat.data  <= lane_of(head, phase);
                beat.sof   <= first_pend;
                beat.eof   <= last_pop;
                phase      <= ~phase;
                first_pend <= 1'b0;
            end else begin
                beat.sof <= 1'b0;
                beat.eof <= 1'b0;
            end
            if (frame_arm) first_pend <= 1'b1;
        end
    end

    // R5: after the closing sample nothing follows until a new frame fills
    eof_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat.eof) |=> !beat_valid);

    // R4: a word is released only after its low lane went out
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> $past(have_word));

endmodule

// File: rtl/trig_frame_unpacker.sv
module trig_frame_unpacker
    import tfu_pkg::*;
#(
    parameter int FRAME_SAMPLES = 8192,
    parameter int BUF_DEPTH     = 4096,
    parameter int MISS_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       word_in,
    input  logic              word_valid,
    input  logic              trig_in,
    output logic [15:0]       smp_out,
    output logic              smp_valid,
    output logic              frame_start,
    output logic              frame_end,
    output logic [MISS_W-1:0] missed_trig,
    output logic              buf_overflow
);
    localparam int FRAME_WORDS = FRAME_SAMPLES / LANES;
    localparam int CW          = $clog2(BUF_DEPTH + 1);

    logic       trig_rise, wr_en, frame_arm, pop, last_pop;
    logic       full, empty;
    logic [CW-1:0] fill;
    word_t      head;
    cap_state_e state;
    smp_beat_t  beat;
    logic       beat_valid;

    tfu_trig_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .trig_async(trig_in), .trig_rise(trig_rise)
    );

    tfu_frame_ctrl #(.FRAME_WORDS(FRAME_WORDS), .MISS_W(MISS_W)) u_ctrl (
        .clk(clk), .rst(rst), .trig_rise(trig_rise), .word_valid(word_valid),
        .last_pop(last_pop), .state(state), .wr_en(wr_en),
        .frame_arm(frame_arm), .missed(missed_trig)
    );

    tfu_word_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(word_in),
        .rd_en(pop), .rd_data(head), .count(fill), .full(full), .empty(empty)
    );

    tfu_unpacker u_unpack (
        .clk(clk), .rst(rst), .head(head), .have_word(!empty),
        .one_left(fill == CW'(1)), .drain_mode(state == ST_DRAIN),
        .frame_arm(frame_arm), .pop(pop), .last_pop(last_pop),
        .beat(beat), .beat_valid(beat_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) buf_overflow <= 1'b0;
        else if (full) buf_overflow <= 1'b1;
    end

    assign smp_out     = beat.data;
    assign smp_valid   = beat_valid;
    assign frame_start = beat.sof;
    assign frame_end   = beat.eof;

    // R9
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        buf_overflow |=> buf_overflow);

    // R5
    marks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start || frame_end) |-> smp_valid);

endmodule

// File: tb/tb_trig_frame_unpacker.sv
module tb_trig_frame_unpacker;

    localparam int FS     = 64;
    localparam int FW     = FS / 2;
    localparam int DEPTH  = 8;
    localparam int MW     = 8;
    localparam int WD_LIM = 100000;

    typedef struct packed {
        logic [15:0] d;
        logic        s;
        logic        e;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   word_in = '0;
    logic          word_valid = 1'b0;
    logic          trig_in = 1'b0;
    logic [15:0]   smp_out;
    logic          smp_valid, frame_start, frame_end, buf_overflow;
    logic [MW-1:0] missed_trig;

    trig_frame_unpacker #(.FRAME_SAMPLES(FS), .BUF_DEPTH(DEPTH), .MISS_W(MW)) dut (
        .clk(clk), .rst(rst), .word_in(word_in), .word_valid(word_valid),
        .trig_in(trig_in), .smp_out(smp_out), .smp_valid(smp_valid),
        .frame_start(frame_start), .frame_end(frame_end),
        .missed_trig(missed_trig), .buf_overflow(buf_overflow)
    );

    always #5 clk = ~clk;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   n_smp = 0, n_frames = 0, n_starts = 0;
    bit   sb_off = 1'b0;
    int   cyc = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIM) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            summary();
        end
    end

    // Monitor: compares each emitted sample against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (!smp_valid && (frame_start || frame_end))
                chk(1'b0, "R5", "frame mark without valid", 1, 0);
            if (smp_valid) begin
                n_smp++;
                if (frame_start) n_starts++;
                if (frame_end)   n_frames++;
                if (!sb_off) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R2/R3", "unexpected sample", longint'(smp_out), -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(smp_out == e.d, "R4/R8", "sample data", smp_out, e.d);
                        chk(frame_start == e.s && frame_end == e.e, "R5",
                            "start/end marks", {frame_start, frame_end}, {e.s, e.e});
                    end
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic fresh_trigger();
        trig_in = 1'b0;
        tick(4);
        trig_in = 1'b1;
        tick(4);
    endtask

    // Driver: sends one frame of words and queues the samples it expects
    task automatic send_frame(int base, bit slow, bit mid_pulse);
        for (int i = 0; i < FW; i++) begin
            logic [15:0] lo, hi;
            lo = 16'(base + 2 * i);
            hi = 16'(base + 2 * i + 1) ^ 16'hA5A5;
            @(posedge clk); #1;
            word_in    = {hi, lo};
            word_valid = 1'b1;
            if (!sb_off) begin
                q.push_back('{d: lo, s: (i == 0), e: 1'b0});
                q.push_back('{d: hi, s: 1'b0, e: (i == FW - 1)});
            end
            if (mid_pulse && i == 4) trig_in = 1'b0;
            if (mid_pulse && i == 9) trig_in = 1'b1;
            if (slow) begin
                @(posedge clk); #1;
                word_valid = 1'b0;
            end
        end
        @(posedge clk); #1;
        word_valid = 1'b0;
    endtask

    task automatic stray_words(int n, int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            word_in    = 32'(base + i) ^ 32'h5A5A_0F0F;
            word_valid = 1'b1;
            @(posedge clk); #1;
            word_valid = 1'b0;
        end
    endtask

    task automatic wait_frames(int target);
        while (n_frames < target) @(posedge clk);
        tick(3);
    endtask

    initial begin
        int smp_before;
        tick(5);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk(smp_valid == 0, "R1", "smp_valid", smp_valid, 0);
        chk(frame_start == 0, "R1", "frame_start", frame_start, 0);
        chk(frame_end == 0, "R1", "frame_end", frame_end, 0);
        chk(missed_trig == 0, "R1", "missed_trig", missed_trig, 0);
        chk(buf_overflow == 0, "R1", "buf_overflow", buf_overflow, 0);

        // R2: words with no trigger edge are ignored
        stray_words(10, 100);
        tick(6);
        chk(n_smp == 0, "R2", "samples without trigger", n_smp, 0);

        // R3/R4/R8: slow frame, followed by late words that must be dropped
        fresh_trigger();
        send_frame(16'h1000, 1'b1, 1'b0);
        stray_words(6, 200);
        wait_frames(1);
        chk(n_smp == FS, "R3", "samples in first frame", n_smp, FS);
        chk(n_starts == 1, "R5", "frame starts", n_starts, 1);
        chk(missed_trig == 0, "R6", "missed_trig after clean frame", missed_trig, 0);

        // R7: trigger still high, no new frame
        stray_words(8, 300);
        tick(10);
        chk(n_smp == FS, "R7", "samples with trigger held high", n_smp, FS);

        // R6: extra edge inside a frame is counted, not acted on
        fresh_trigger();
        send_frame(16'h7F00, 1'b1, 1'b1);
        wait_frames(2);
        chk(missed_trig == 1, "R6", "missed_trig", missed_trig, 1);
        stray_words(8, 400);
        tick(10);
        chk(n_frames == 2, "R6", "frames after missed edge", n_frames, 2);
        chk(n_smp == 2 * FS, "R6", "samples after missed edge", n_smp, 2 * FS);

        // R10: a fresh edge right after the end starts the next frame
        trig_in = 1'b0;
        tick(3);
        trig_in = 1'b1;
        tick(4);
        send_frame(16'hFFF0, 1'b1, 1'b0);
        wait_frames(3);
        chk(n_frames == 3, "R10", "frame after rearm", n_frames, 3);
        chk(q.size() == 0, "R8", "expected samples left", q.size(), 0);
        chk(buf_overflow == 0, "R9", "overflow before full-rate frame", buf_overflow, 0);

        // R9: full-rate frame into a small buffer fills it
        sb_off     = 1'b1;
        smp_before = n_smp;
        fresh_trigger();
        send_frame(16'h2222, 1'b0, 1'b0);
        wait_frames(4);
        chk(buf_overflow == 1, "R9", "overflow flag", buf_overflow, 1);
        chk((n_smp - smp_before) < FS, "R9", "samples kept when full",
            n_smp - smp_before, FS - 1);
        tick(20);
        chk(buf_overflow == 1, "R9", "overflow sticky", buf_overflow, 1);
        chk(n_starts == 4, "R5", "one start per frame", n_starts, 4);

        summary();
    end

endmodule